// File: doc/BRIEF.md
# Packet Header SEC-DED Code Unit

This unit protects a 24-bit packet header with an 8-bit error-correcting code. The header is the identifier byte followed by two data bytes. The encoder side takes a header and returns its code byte. The decoder side takes a received header and a received code byte. It returns the header with any single flipped bit repaired, plus two flags: one for a repaired error and one for an error it cannot repair.

Only six of the eight code bits carry parity. The top two are always zero. Each header bit maps to a distinct six-bit parity column of odd weight (three or five ones). A single bit error therefore gives a syndrome that either equals one column or has exactly one bit set. A double error gives a syndrome of even weight, which matches neither. The arithmetic is combinational. A parameter adds one register stage on every output.

Top module: `hdr_ecc_codec`

## Requirements
- R1: Code bit k (k = 0..5) is the XOR of the header bits in these sets. Bit 0: {0,1,2,4,5,7,10,11,13,16,20,21,22,23}. Bit 1: {0,1,3,4,6,8,10,12,14,17,20,21,22,23}. Bit 2: {0,2,3,5,6,9,11,12,15,18,20,21,22}. Bit 3: {1,2,3,7,8,9,13,14,15,19,20,21,23}. Bit 4: {4..9,16..20,22,23}. Bit 5: {10..19,21,22,23}.
- R2: Bits 7 and 6 of the produced code byte are always 0.
- R3: When the received code byte equals the code of the received header, the header passes out unchanged and both flags are low.
- R4: A single flipped header bit is restored in the output header, the repaired flag is high and the unrepairable flag is low.
- R5: A single flipped code bit among bits 5..0 leaves the output header equal to the received header, with the repaired flag high and the unrepairable flag low.
- R6: Any two flipped bits among the 32 codeword bits (header plus code byte) raise the unrepairable flag, keep the repaired flag low, and pass the received header out unmodified.
- R7: A received code byte with bit 7 or bit 6 differing from zero, alone or with other errors, raises the unrepairable flag and passes the received header out unmodified.
- R8: The repaired and unrepairable flags are never high together.
- R9: With OUT_REG = 1, every output reflects the inputs present at the previous rising clock edge, and an active-low reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data_i | input | 24 | Header to encode |
| enc_ecc_o | output | 8 | Code byte for enc_data_i |
| dec_data_i | input | 24 | Received header |
| dec_ecc_i | input | 8 | Received code byte |
| dec_data_o | output | 24 | Header after correction |
| dec_fixed_o | output | 1 | A single error was repaired |
| dec_fatal_o | output | 1 | An error was found that cannot be repaired |

## Verification
A wrong parity column shows up the moment the encoder sees any header that uses the affected bit. It also shows on the decoder side: a single flip on that bit is either repaired in the wrong place or reported as fatal, visible on the first registered output after the input is applied. A fault in the classifier shows as both flags high, a clean codeword flagged, or a double error presented as repaired with a corrupted header. These appear one clock after the offending pattern reaches the inputs. The sweep covers every single and double flip position across several headers, so each column and each pair of columns is exercised.

// File: rtl/hdr_ecc_pkg.sv
`timescale 1ns/1ps
package hdr_ecc_pkg;
  localparam int unsigned HDR_W  = 24;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned PAR_W  = 6;
  localparam int unsigned PAD_W  = CODE_W - PAR_W;
  localparam int unsigned COL_SPACE = 1 << PAR_W;

  // Parity column of header bit idx: odd-weight values taken in ascending
  // order, all weight-3 values first, then weight-5 values.
  function automatic logic [PAR_W-1:0] par_column(input int unsigned idx);
    logic [PAR_W-1:0] col;
    logic [PAR_W-1:0] cand;
    int unsigned seen;
    col  = '0;
    seen = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < int'(COL_SPACE); v++) begin
        cand = PAR_W'(v);
        if ($countones(cand) == w) begin
          if (seen == idx) col = cand;
          seen++;
        end
      end
    end
    return col;
  endfunction

  // Header bits contributing to parity bit p.
  function automatic logic [HDR_W-1:0] par_mask(input int unsigned p);
    logic [HDR_W-1:0] m;
    logic [PAR_W-1:0] c;
    m = '0;
    for (int i = 0; i < int'(HDR_W); i++) begin
      c    = par_column(i);
      m[i] = c[p];
    end
    return m;
  endfunction

  // Full code byte for a header.
  function automatic logic [CODE_W-1:0] code_of(input logic [HDR_W-1:0] d);
    logic [CODE_W-1:0] e;
    e = '0;
    for (int p = 0; p < int'(PAR_W); p++) e[p] = ^(d & par_mask(p));
    return e;
  endfunction
endpackage

// File: rtl/hdr_ecc_encoder.sv
`timescale 1ns/1ps
module hdr_ecc_encoder
  import hdr_ecc_pkg::*;
(
  input  logic [HDR_W-1:0]  data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [PAR_W-1:0] par;

  for (genvar p = 0; p < PAR_W; p++) begin : g_par
    localparam logic [HDR_W-1:0] MASK = par_mask(p);
    assign par[p] = ^(data_i & MASK);
  end

  assign code_o = {{PAD_W{1'b0}}, par};
endmodule

// File: rtl/hdr_ecc_syndrome.sv
`timescale 1ns/1ps
module hdr_ecc_syndrome
  import hdr_ecc_pkg::*;
(
  input  logic [HDR_W-1:0]  data_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] syn_o
);
  logic [CODE_W-1:0] recomputed;

  hdr_ecc_encoder u_recode (
    .data_i (data_i),
    .code_o (recomputed)
  );

  assign syn_o = code_i ^ recomputed;
endmodule

// File: rtl/hdr_ecc_classify.sv
`timescale 1ns/1ps
module hdr_ecc_classify
  import hdr_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] syn_i,
  output logic [HDR_W-1:0]  flip_o,
  output logic              fixed_o,
  output logic              fatal_o
);
  logic             pad_clean;
  logic             par_single;
  logic             any_err;
  logic [PAR_W-1:0] par_syn;

  assign par_syn   = syn_i[PAR_W-1:0];
  assign pad_clean = (syn_i[CODE_W-1:PAR_W] == '0);
  assign any_err   = (syn_i != '0);

  for (genvar i = 0; i < HDR_W; i++) begin : g_hit
    localparam logic [PAR_W-1:0] COL = par_column(i);
    assign flip_o[i] = pad_clean && (par_syn == COL);
  end

  assign par_single = pad_clean && $onehot(par_syn);
  assign fixed_o    = (|flip_o) || par_single;
  assign fatal_o    = any_err && !fixed_o;
endmodule

// File: rtl/hdr_ecc_codec.sv
`timescale 1ns/1ps
module hdr_ecc_codec
  import hdr_ecc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HDR_W-1:0]  enc_data_i,
  output logic [CODE_W-1:0] enc_ecc_o,
  input  logic [HDR_W-1:0]  dec_data_i,
  input  logic [CODE_W-1:0] dec_ecc_i,
  output logic [HDR_W-1:0]  dec_data_o,
  output logic              dec_fixed_o,
  output logic              dec_fatal_o
);
  logic [CODE_W-1:0] enc_code_c;
  logic [CODE_W-1:0] syn_c;
  logic [HDR_W-1:0]  flip_c;
  logic [HDR_W-1:0]  data_c;
  logic              fixed_c;
  logic              fatal_c;

  hdr_ecc_encoder u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_c)
  );

  hdr_ecc_syndrome u_syn (
    .data_i (dec_data_i),
    .code_i (dec_ecc_i),
    .syn_o  (syn_c)
  );

  hdr_ecc_classify u_cls (
    .syn_i   (syn_c),
    .flip_o  (flip_c),
    .fixed_o (fixed_c),
    .fatal_o (fatal_c)
  );

  assign data_c = dec_data_i ^ flip_c;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enc_ecc_o   <= '0;
        dec_data_o  <= '0;
        dec_fixed_o <= 1'b0;
        dec_fatal_o <= 1'b0;
      end else begin
        enc_ecc_o   <= enc_code_c;
        dec_data_o  <= data_c;
        dec_fixed_o <= fixed_c;
        dec_fatal_o <= fatal_c;
      end
    end

    // R9
    out_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dec_data_o == $past(data_c) && enc_ecc_o == $past(enc_code_c)));
  end else begin : g_comb
    assign enc_ecc_o   = enc_code_c;
    assign dec_data_o  = data_c;
    assign dec_fixed_o = fixed_c;
    assign dec_fatal_o = fatal_c;
  end

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed_o && dec_fatal_o));

  // R3
  loopback_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_data_i == enc_data_i && dec_ecc_i == enc_code_c)
      |-> (!fixed_c && !fatal_c && data_c == dec_data_i));

  // R4
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flip_c) <= 1) && ((flip_c != '0) -> fixed_c));

  // R6
  even_syn_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_c != '0 && (^syn_c) == 1'b0) |-> (fatal_c && flip_c == '0));

  // R7
  pad_syn_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_c[CODE_W-1:PAR_W] != '0) |-> (fatal_c && data_c == dec_data_i));
endmodule

// File: tb/hdr_ecc_codec_tb.sv
`timescale 1ns/1ps
module hdr_ecc_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] enc_data_i = '0;
  logic [7:0]  enc_ecc_o;
  logic [23:0] dec_data_i = '0;
  logic [7:0]  dec_ecc_i = '0;
  logic [23:0] dec_data_o;
  logic        dec_fixed_o;
  logic        dec_fatal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdr_ecc_codec dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data_i  (enc_data_i),
    .enc_ecc_o   (enc_ecc_o),
    .dec_data_i  (dec_data_i),
    .dec_ecc_i   (dec_ecc_i),
    .dec_data_o  (dec_data_o),
    .dec_fixed_o (dec_fixed_o),
    .dec_fatal_o (dec_fatal_o)
  );

  // Parity sets written as bit masks, taken straight from R1.
  localparam logic [23:0] M0 = 24'hF12CB7;
  localparam logic [23:0] M1 = 24'hF2555B;
  localparam logic [23:0] M2 = 24'h749A6D;
  localparam logic [23:0] M3 = 24'hB8E38E;
  localparam logic [23:0] M4 = 24'hDF03F0;
  localparam logic [23:0] M5 = 24'hEFFC00;

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    return {2'b00, ^(d & M5), ^(d & M4), ^(d & M3), ^(d & M2), ^(d & M1), ^(d & M0)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one header with a given error vector over {code, header}.
  task automatic run_case(input logic [23:0] d, input logic [31:0] err, input string req);
    logic [7:0]  e;
    logic [31:0] cw;
    logic [23:0] exp_d;
    bit          exp_fix;
    bit          exp_fat;
    int          n;
    e  = ref_ecc(d);
    cw = {e, d} ^ err;
    n  = $countones(err);
    if (n == 0) begin
      exp_d = d; exp_fix = 0; exp_fat = 0;
    end else if (n == 1 && err[29:0] != '0) begin
      exp_d = d; exp_fix = 1; exp_fat = 0;
    end else begin
      exp_d = cw[23:0]; exp_fix = 0; exp_fat = 1;
    end
    @(negedge clk);
    enc_data_i = d;
    dec_data_i = cw[23:0];
    dec_ecc_i  = cw[31:24];
    @(negedge clk);
    check(enc_ecc_o == e, "R1 R2 encode", 64'(enc_ecc_o), 64'(e));
    check(dec_data_o == exp_d && dec_fixed_o == exp_fix && dec_fatal_o == exp_fat, req,
          {38'd0, dec_fixed_o, dec_fatal_o, dec_data_o},
          {38'd0, exp_fix, exp_fat, exp_d});
  endtask

  function automatic logic [23:0] next_pat(input logic [23:0] s);
    logic [23:0] x;
    x = s ^ (s << 7);
    x = x ^ (x >> 9);
    x = x ^ (x << 3);
    return (x == '0) ? 24'h5A5A5A : x;
  endfunction

  initial begin
    logic [23:0] pat;
    // R9: reset holds outputs at zero despite active inputs
    enc_data_i = 24'hFFFFFF;
    dec_data_i = 24'h123456;
    dec_ecc_i  = 8'hC3;
    repeat (3) @(negedge clk);
    check(enc_ecc_o == 8'h00 && dec_data_o == '0 && !dec_fixed_o && !dec_fatal_o,
          "R9 reset", {30'd0, dec_fixed_o, dec_fatal_o, dec_data_o, enc_ecc_o}, 64'd0);
    rst_n = 1'b1;

    // R9: latency of one edge
    @(negedge clk);
    enc_data_i = 24'h000001;
    @(negedge clk);
    enc_data_i = 24'h800000;
    #1;
    check(enc_ecc_o == ref_ecc(24'h000001), "R9 holds until edge",
          64'(enc_ecc_o), 64'(ref_ecc(24'h000001)));
    @(negedge clk);
    check(enc_ecc_o == ref_ecc(24'h800000), "R9 updates after edge",
          64'(enc_ecc_o), 64'(ref_ecc(24'h800000)));

    // R1 R3: walking single header bits, clean decode
    for (int b = 0; b < 24; b++) run_case(24'(1) << b, 32'd0, "R3 clean walk");
    run_case(24'h000000, 32'd0, "R3 clean zero");
    run_case(24'hFFFFFF, 32'd0, "R3 clean ones");

    pat = 24'hACE135;
    for (int k = 0; k < 48; k++) begin
      run_case(pat, 32'd0, "R3 clean");
      for (int b = 0; b < 24; b++) run_case(pat, 32'(1) << b, "R4 header flip");
      for (int b = 24; b < 30; b++) run_case(pat, 32'(1) << b, "R5 code flip");
      for (int b = 30; b < 32; b++) run_case(pat, 32'(1) << b, "R7 pad flip");
      if (k < 12) begin
        for (int a = 0; a < 32; a++)
          for (int b = a + 1; b < 32; b++)
            run_case(pat, (32'(1) << a) | (32'(1) << b), "R6 R8 double flip");
      end
      pat = next_pat(pat);
    end
    // R7 with additional header error
    run_case(24'h00FF00, 32'h8000_0010, "R7 pad plus header");
    run_case(24'h00FF00, 32'hC000_0000, "R7 both pad bits");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule